// File: doc/BRIEF.md
# Up-Down PWM Generator with Per-Output Action Qualifiers

This block produces two pulse-width-modulated outputs, A and B, from one time-base counter. The counter climbs from zero to a programmable period and then falls back to zero. A symmetric (centre-aligned) waveform results. Each output has its own action table. The table says what to do with that output on each counter event. Events are counter at zero, counter at period, and a compare match on compare A or compare B. A compare match is qualified by the count direction.

Software programs the block through a simple write port. It sets the period, two compare values, the two action tables and a shadow-control word. Compare values normally go into shadow copies. The active copies take them over when the counter passes through zero, so a duty change never lands in the middle of a cycle.

A common use is a pair of equal-width pulses. Output A is set at zero and cleared at compare A on the way up. Output B is set at the period and cleared at compare B on the way down. Compare B is programmed to period minus compare A.

Top module: `updown_pwm_aq`

## Requirements
- R1: While `tb_en` is high, the counter steps by one per clock between 0 and the period. When it is at the period while rising, or at 0 while falling, it reverses on the next clock: period goes to period-1 and 0 goes to 1. A period of 0 holds the counter at 0. `cnt_up` gives the direction of the step that produced the current count.
- R2: Each action table is 12 bits of 2-bit fields: [1:0] zero, [3:2] period, [5:4] compare A rising, [7:6] compare A falling, [9:8] compare B rising, [11:10] compare B falling. Codes are 00 none, 01 drive low, 10 drive high, 11 invert. An output changes on the clock edge at which the counter shows the event value.
- R3: A compare match at the period or at 0 counts under the direction in force when the counter arrived there. At the period that is rising; at 0 reached on the way down it is falling.
- R4: When several events occur on one clock, the event whose field is non-zero and has the highest priority decides. The order from highest is zero, period, compare B, compare A.
- R5: Register addresses are 0 period, 1 compare A, 2 compare B, 3 table A, 4 table B and 5 shadow control (bit 0 for compare A, bit 1 for compare B, reset 1). With shadowing on, a compare write reaches the active value only on a clock at which the running counter is at 0. With shadowing off, it takes effect on the next clock.
- R6: A period write takes effect on the next clock. A counter above a reduced period heads down.
- R7: With `tb_en` low the counter and both outputs hold their values, even across register writes.
- R8: With A set at zero and cleared at compare A rising, and B set at period and cleared at compare B falling, and compare B = period - compare A, each output is high for exactly compare A clocks per period.
- R9: Reset clears the counter, both outputs, the period, the compare values and the action tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_en | input | 1 | Global time-base enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CW | Write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| cnt | output | CW | Current counter value |
| cnt_up | output | 1 | Direction of the last counter step, 1 rising |

## Verification
The first pattern is the complementary set/clear setup with compare B equal to period minus compare A. Measured over several periods, it tells a correctly aligned pair from one where the turning points or the direction qualification are off by a clock. Invert actions with the compare values placed on the turning points show whether a match at the period or at zero takes the arriving direction. Coincident compare A and compare B values with conflicting actions expose the priority order. Mid-period compare writes with shadowing on and off, period shrinks and a zero period, and a frozen time base separate the load timing and the enable gating from the main waveform path.

// File: rtl/updown_pwm_aq.sv
module updown_pwm_aq #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic [CW-1:0] cnt,
  output logic          cnt_up
);

  localparam int QW = 12;
  localparam logic [AW-1:0] A_PRD  = AW'(0);
  localparam logic [AW-1:0] A_CMPA = AW'(1);
  localparam logic [AW-1:0] A_CMPB = AW'(2);
  localparam logic [AW-1:0] A_AQA  = AW'(3);
  localparam logic [AW-1:0] A_AQB  = AW'(4);
  localparam logic [AW-1:0] A_CTRL = AW'(5);

  logic [CW-1:0] prd_q, sh_a_q, sh_b_q, ac_a_q, ac_b_q, cnt_q, cnt_d;
  logic [QW-1:0] aq_a_q, aq_b_q;
  logic [1:0]    shd_q, code_a, code_b;
  logic          up_q, up_d, pa_q, pb_q;
  logic          at_zero, at_prd, hit_a, hit_b;

  function automatic logic [1:0] pick(input logic [QW-1:0] q, input logic z,
                                      input logic p, input logic ha,
                                      input logic hb, input logic u);
    logic [1:0] r, f;
    r = 2'b00;
    f = u ? q[5:4] : q[7:6];
    if (ha && f != 2'b00) r = f;
    f = u ? q[9:8] : q[11:10];
    if (hb && f != 2'b00) r = f;
    if (p && q[3:2] != 2'b00) r = q[3:2];
    if (z && q[1:0] != 2'b00) r = q[1:0];
    return r;
  endfunction

  function automatic logic apply(input logic cur, input logic [1:0] c);
    case (c)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  assign at_zero = (cnt_q == '0);
  assign at_prd  = (cnt_q == prd_q);
  assign hit_a   = (cnt_q == ac_a_q);
  assign hit_b   = (cnt_q == ac_b_q);
  assign code_a  = pick(aq_a_q, at_zero, at_prd, hit_a, hit_b, up_q);
  assign code_b  = pick(aq_b_q, at_zero, at_prd, hit_a, hit_b, up_q);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (prd_q == '0) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (up_q) begin
      if (cnt_q >= prd_q) begin
        up_d  = 1'b0;
        cnt_d = cnt_q - 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (at_zero) begin
      up_d  = 1'b1;
      cnt_d = CW'(1);
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
    end else if (tb_en) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      pa_q  <= apply(pa_q, code_a);
      pb_q  <= apply(pb_q, code_b);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_q  <= '0;
      sh_a_q <= '0;
      sh_b_q <= '0;
      ac_a_q <= '0;
      ac_b_q <= '0;
      aq_a_q <= '0;
      aq_b_q <= '0;
      shd_q  <= 2'b11;
    end else begin
      if (wr_en && wr_addr == A_PRD)  prd_q  <= wr_data;
      if (wr_en && wr_addr == A_AQA)  aq_a_q <= wr_data[QW-1:0];
      if (wr_en && wr_addr == A_AQB)  aq_b_q <= wr_data[QW-1:0];
      if (wr_en && wr_addr == A_CTRL) shd_q  <= wr_data[1:0];
      if (wr_en && wr_addr == A_CMPA) sh_a_q <= wr_data;
      if (wr_en && wr_addr == A_CMPB) sh_b_q <= wr_data;
      if (wr_en && wr_addr == A_CMPA && !shd_q[0])
        ac_a_q <= wr_data;
      else if (tb_en && at_zero && shd_q[0])
        ac_a_q <= sh_a_q;
      if (wr_en && wr_addr == A_CMPB && !shd_q[1])
        ac_b_q <= wr_data;
      else if (tb_en && at_zero && shd_q[1])
        ac_b_q <= sh_b_q;
    end
  end

  assign pwm_a  = pa_q;
  assign pwm_b  = pb_q;
  assign cnt    = cnt_q;
  assign cnt_up = up_q;

endmodule

// File: rtl/updown_pwm_aq_chk.sv
module updown_pwm_aq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tb_en,
  input logic [CW-1:0] cnt,
  input logic          up,
  input logic [CW-1:0] prd,
  input logic [1:0]    zero_fld,
  input logic [CW-1:0] ac_a,
  input logic [CW-1:0] sh_a,
  input logic          shd_a,
  input logic          pwm_a,
  input logic          pwm_b
);

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && cnt != '0 && cnt < prd) |=>
      (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));

  p_top_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && up && prd != '0 && cnt == prd) |=> !up);

  p_bottom_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && !up && prd != '0 && cnt == '0) |=> (up && cnt == CW'(1)));

  p_zero_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && cnt == '0 && zero_fld == 2'b10) |=> pwm_a);

  p_shadow_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && cnt == '0 && shd_a) |=> (ac_a == $past(sh_a)));

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en |=> ($stable(cnt) && $stable(pwm_a) && $stable(pwm_b)));

endmodule

bind updown_pwm_aq updown_pwm_aq_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .cnt(cnt_q), .up(up_q),
  .prd(prd_q), .zero_fld(aq_a_q[1:0]), .ac_a(ac_a_q), .sh_a(sh_a_q),
  .shd_a(shd_q[0]), .pwm_a(pa_q), .pwm_b(pb_q)
);

// File: tb/updown_pwm_aq_tb_top.sv
module updown_pwm_aq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b, cnt_up;
  logic [15:0] cnt;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  string cur_req = "R9";

  int m_cnt, m_prd, m_sa, m_sb, m_aa, m_ab, m_qa, m_qb, m_shd, ca, cb;
  bit m_up, m_a, m_b;

  always #4 clk = ~clk;

  updown_pwm_aq dut_i (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .cnt(cnt), .cnt_up(cnt_up)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int fld(input int q, input int i);
    return (q >> (2 * i)) & 3;
  endfunction

  function automatic int mpick(input int q, input int c, input bit u);
    int r, f;
    r = 0;
    if (c == m_aa) begin f = u ? fld(q, 2) : fld(q, 3); if (f != 0) r = f; end
    if (c == m_ab) begin f = u ? fld(q, 4) : fld(q, 5); if (f != 0) r = f; end
    if (c == m_prd && fld(q, 1) != 0) r = fld(q, 1);
    if (c == 0 && fld(q, 0) != 0) r = fld(q, 0);
    return r;
  endfunction

  function automatic bit mapply(input bit cur, input int c);
    if (c == 1) return 1'b0;
    if (c == 2) return 1'b1;
    if (c == 3) return ~cur;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_prd = 0; m_sa = 0; m_sb = 0; m_aa = 0; m_ab = 0;
      m_qa = 0; m_qb = 0; m_shd = 3; m_a = 0; m_b = 0;
    end else begin
      if (tb_en) begin
        ca = mpick(m_qa, m_cnt, m_up);
        cb = mpick(m_qb, m_cnt, m_up);
        m_a = mapply(m_a, ca);
        m_b = mapply(m_b, cb);
        if (m_cnt == 0 && (m_shd & 1) != 0) m_aa = m_sa;
        if (m_cnt == 0 && (m_shd & 2) != 0) m_ab = m_sb;
        if (m_prd == 0) begin m_cnt = 0; m_up = 1; end
        else if (m_up) begin
          if (m_cnt >= m_prd) begin m_up = 0; m_cnt--; end else m_cnt++;
        end else if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
        else m_cnt--;
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_prd = wr_data;
          3'd1: begin m_sa = wr_data; if ((m_shd & 1) == 0) m_aa = wr_data; end
          3'd2: begin m_sb = wr_data; if ((m_shd & 2) == 0) m_ab = wr_data; end
          3'd3: m_qa = wr_data & 16'hFFF;
          3'd4: m_qb = wr_data & 16'hFFF;
          3'd5: m_shd = wr_data & 3;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(cnt == 16'(m_cnt), "R1 counter", int'(cnt), m_cnt);
      chk(cnt_up == m_up, "R1 direction", int'(cnt_up), int'(m_up));
      chk(pwm_a == m_a, {cur_req, " pwm_a"}, int'(pwm_a), int'(m_a));
      chk(pwm_b == m_b, {cur_req, " pwm_b"}, int'(pwm_b), int'(m_b));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int v, input bit u);
    do @(negedge clk); while (!(int'(cnt) == v && cnt_up == u));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int ha, hb, ta, tb, mx, bad;
    bit pa, pb;
    logic [15:0] sc;
    logic sa, sbv;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(cnt == 0 && pwm_a == 0 && pwm_b == 0, "R9 reset", int'(cnt) + pwm_a + pwm_b, 0);
    live = 1'b1;

    cur_req = "R2";
    wr(0, 20); wr(1, 6); wr(2, 14); wr(3, 12'h012); wr(4, 12'h408);
    @(negedge clk); tb_en = 1'b1;
    repeat (80) @(negedge clk);

    cur_req = "R8";
    wait_cnt(0, 0);
    ha = 0; hb = 0;
    for (int i = 0; i < 160; i++) begin
      ha += pwm_a; hb += pwm_b;
      @(negedge clk);
    end
    chk(ha == 24, "R8 high time A", ha, 24);
    chk(hb == ha, "R8 high time B equals A", hb, ha);

    cur_req = "R5";
    wait_cnt(1, 1);
    wr(1, 10);
    wait_cnt(8, 1);
    chk(pwm_a == 0, "R5 shadow holds old compare", int'(pwm_a), 0);
    wait_cnt(8, 1);
    chk(pwm_a == 1, "R5 shadow loaded at zero", int'(pwm_a), 1);
    wr(5, 0);
    wait_cnt(3, 1);
    wr(1, 5);
    wait_cnt(7, 1);
    chk(pwm_a == 0, "R5 direct compare write", int'(pwm_a), 0);

    cur_req = "R3";
    wr(1, 20); wr(2, 0); wr(3, 12'h030); wr(4, 12'hC00);
    wait_cnt(0, 0);
    pa = pwm_a; pb = pwm_b; ta = 0; tb = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (pwm_a != pa) ta++;
      if (pwm_b != pb) tb++;
      pa = pwm_a; pb = pwm_b;
    end
    chk(ta == 2, "R3 match at period counts rising", ta, 2);
    chk(tb == 2, "R3 match at zero counts falling", tb, 2);

    cur_req = "R4";
    wr(1, 5); wr(2, 5); wr(3, 12'h960);
    wait_cnt(20, 1);
    wait_cnt(2, 1);
    chk(pwm_a == 1, "R4 compare B wins falling", int'(pwm_a), 1);
    wait_cnt(10, 1);
    chk(pwm_a == 0, "R4 compare B wins rising", int'(pwm_a), 0);

    cur_req = "R6";
    wr(0, 8);
    repeat (40) @(negedge clk);
    mx = 0;
    for (int i = 0; i < 64; i++) begin
      if (int'(cnt) > mx) mx = int'(cnt);
      @(negedge clk);
    end
    chk(mx == 8, "R6 reduced period peak", mx, 8);
    wr(0, 0);
    repeat (30) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (cnt != 0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R1 zero period holds", bad, 0);
    wr(0, 20);
    repeat (60) @(negedge clk);

    cur_req = "R7";
    tb_en = 1'b0;
    @(negedge clk);
    sc = cnt; sa = pwm_a; sbv = pwm_b;
    wr(3, 12'h0FF); wr(1, 3);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (cnt != sc || pwm_a != sa || pwm_b != sbv) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 frozen while disabled", bad, 0);
    tb_en = 1'b1;
    repeat (100) @(negedge clk);

    live = 1'b0;
    finish_run();
  end

endmodule